// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Requests

This block buffers words that arrive from a serial shift register before a bus master or DMA agent collects them. Each incoming word is pushed into a small first-in first-out store. A read strobe pops the oldest word, which is always visible on the read-data port. A 3-bit selector picks which fill condition drives the data request output, from "anything present" up to "completely full".

Besides the request, the block keeps an urgent-level flag with hysteresis. The flag latches once the fill reaches a programmable upper quarter. It drops only when the fill falls below a separately programmed lower level.

When a word meets a full store, one control bit decides what happens. Either the new word is dropped, or it replaces the oldest word. Both cases set a sticky overrun flag, which software clears with a write-one strobe. In master operation, an optional word counter counts down on each accepted word. It raises a halt output when it reaches zero or when the store is full, so reception stops before any overrun can happen.

Top module: `rx_wm_fifo`

## Requirements
- R1: `rx_req` follows `cfg_req_sel` (with Q = DEPTH/4): code 0 never asserts; code 1 asserts when fill != 0; code 2 when fill >= Q; code 3 when fill >= 2Q; code 4 when fill >= 3Q; code 5 when fill == DEPTH.
- R2: Select codes 6 and 7 never assert `rx_req`.
- R3: With `cfg_ovwr`=0, a word accepted while fill == DEPTH and no pop is taking place is dropped. Fill and the word at the head stay unchanged.
- R4: With `cfg_ovwr`=1, a word accepted while fill == DEPTH and no pop is taking place removes the oldest word and is appended at the tail. Fill stays at DEPTH.
- R5: `ovr_flag` sets on the edge after a word is accepted while fill == DEPTH with no pop, in either mode. It then holds until an `ovr_clr` pulse. A new overrun in the same cycle as the clear wins.
- R6: With `urg_en`=1, `urg_flag` sets on the edge after fill >= (`cfg_urg_lvl`+1)*Q.
- R7: Once set, `urg_flag` stays set until fill meets the lower level given by `cfg_reg_wm`: code 0 means fill == 0, and code n (1..3) means fill < n*Q. The set condition has priority over the clear. The flag clears on the edge after `urg_en` is low.
- R8: A `wc_load` pulse loads `wc_val` into `wc_count`. Otherwise, in master operation with `wc_en`=1, each accepted word decrements `wc_count` by one.
- R9: In master operation with `wc_en`=1, `rx_halt` is high while `wc_count` == 0 or fill == DEPTH. A word presented while `rx_halt` is high is ignored: no push, no count change, no overrun.
- R10: With `cfg_master`=0, `wc_en` has no effect: `rx_halt` stays low and `wc_count` changes only on `wc_load`.
- R11: Words leave in arrival order, and `rd_data` shows the oldest word whenever fill != 0. A pop while fill == 0 is ignored. A pop and a push in the same cycle are both accepted.
- R12: `rx_req` is decoded from the registered fill. It therefore changes on the first edge after the push or pop that moves the fill across the selected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word from shift register is present |
| in_data | input | DATA_W | Incoming word |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | DATA_W | Head (oldest) word |
| fill | output | CNT_W | Number of stored words |
| cfg_req_sel | input | 3 | Request condition select |
| cfg_ovwr | input | 1 | 1: overwrite oldest on full, 0: drop new |
| cfg_urg_en | input | 1 | Urgent flag enable |
| cfg_urg_lvl | input | 2 | Urgent set level, (code+1) quarters |
| cfg_reg_wm | input | 2 | Lower level that releases the urgent flag |
| cfg_master | input | 1 | Master operation |
| wc_en | input | 1 | Word counter enable |
| wc_load | input | 1 | Load word counter |
| wc_val | input | WC_W | Word counter load value |
| ovr_clr | input | 1 | Write-one-to-clear for overrun flag |
| rx_req | output | 1 | Data request |
| urg_flag | output | 1 | Latched urgent level flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| rx_halt | output | 1 | Stop reception (counter at zero or store full) |
| wc_count | output | WC_W | Current word counter |

## Verification
A corrupted pointer or count shows up at the ports on the very next edge. `fill` moves by the wrong amount, or `rd_data` shows a word that is out of order against the arrival sequence. A wrong hysteresis state shows as `urg_flag` disagreeing with the fill history within one cycle of crossing either level. Errors in the counter or the halt logic show as an extra or missing push, or a spurious overrun, on the edge after the offending word. The bench therefore compares every output on every cycle against a queue-based model. It runs random configuration phases and directed full-store cases.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  typedef enum logic [2:0] {
    REQ_OFF    = 3'd0,
    REQ_NEMPTY = 3'd1,
    REQ_Q1     = 3'd2,
    REQ_Q2     = 3'd3,
    REQ_Q3     = 3'd4,
    REQ_FULL   = 3'd5,
    REQ_RSV6   = 3'd6,
    REQ_RSV7   = 3'd7
  } req_sel_e;

  // Pointer successor with wrap at an arbitrary depth
  function automatic int unsigned ptr_succ(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxwm_store.sv
module rxwm_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovwr_mode,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill,
  output logic              full,
  output logic              overrun_evt
);
  import rxwm_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop, do_wr, drop_old, rd_adv;

  assign full = (cnt_q == FULL_CNT);

  always_comb begin
    do_pop      = rd_en && (cnt_q != '0);
    do_wr       = wr_req && (!full || do_pop || ovwr_mode);
    drop_old    = do_wr && full && !do_pop;
    overrun_evt = wr_req && full && !do_pop;
    rd_adv      = do_pop || drop_old;
    wr_ptr_d    = wr_ptr_q;
    rd_ptr_d    = rd_ptr_q;
    cnt_d       = cnt_q;
    if (do_wr)
      wr_ptr_d = PTR_W'(ptr_succ(int'(wr_ptr_q), DEPTH));
    if (rd_adv)
      rd_ptr_d = PTR_W'(ptr_succ(int'(rd_ptr_q), DEPTH));
    if (do_wr && !rd_adv)
      cnt_d = cnt_q + 1'b1;
    else if (!do_wr && rd_adv)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (do_wr)
      mem_q[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem_q[rd_ptr_q];
  assign fill    = cnt_q;

endmodule

// File: rtl/rxwm_level.sv
module rxwm_level #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic [2:0]       req_sel,
  input  logic             urg_en,
  input  logic [1:0]       urg_lvl,
  input  logic [1:0]       reg_wm,
  output logic             rx_req,
  output logic             urg_flag
);
  import rxwm_pkg::*;

  localparam int QTR = DEPTH / 4;

  // at_lvl[0]: not empty; at_lvl[k]: fill >= k quarters
  logic [4:0] at_lvl;
  logic       urg_set, urg_clr, urg_q, urg_d;

  assign at_lvl[0] = (fill != '0);
  for (genvar k = 1; k <= 4; k++) begin : g_qtr
    assign at_lvl[k] = (fill >= CNT_W'(k * QTR));
  end

  always_comb begin
    case (req_sel_e'(req_sel))
      REQ_NEMPTY: rx_req = at_lvl[0];
      REQ_Q1:     rx_req = at_lvl[1];
      REQ_Q2:     rx_req = at_lvl[2];
      REQ_Q3:     rx_req = at_lvl[3];
      REQ_FULL:   rx_req = at_lvl[4];
      default:    rx_req = 1'b0;
    endcase
  end

  always_comb begin
    urg_set = at_lvl[3'(urg_lvl) + 3'd1];
    urg_clr = !at_lvl[3'(reg_wm)];
    urg_d   = urg_en && (urg_set || (urg_q && !urg_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) urg_q <= 1'b0;
    else        urg_q <= urg_d;
  end

  assign urg_flag = urg_q;

endmodule

// File: rtl/rxwm_wordcnt.sv
module rxwm_wordcnt #(
  parameter int WC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master,
  input  logic            wc_en,
  input  logic            load,
  input  logic [WC_W-1:0] load_val,
  input  logic            word_in,
  input  logic            fifo_full,
  output logic            halt,
  output logic [WC_W-1:0] count
);

  logic            active, dec;
  logic [WC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    active = master && wc_en;
    halt   = active && ((cnt_q == '0) || fifo_full);
    dec    = active && word_in && !halt;
    cnt_d  = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int WC_W   = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill,
  input  logic [2:0]        cfg_req_sel,
  input  logic              cfg_ovwr,
  input  logic              cfg_urg_en,
  input  logic [1:0]        cfg_urg_lvl,
  input  logic [1:0]        cfg_reg_wm,
  input  logic              cfg_master,
  input  logic              wc_en,
  input  logic              wc_load,
  input  logic [WC_W-1:0]   wc_val,
  input  logic              ovr_clr,
  output logic              rx_req,
  output logic              urg_flag,
  output logic              ovr_flag,
  output logic              rx_halt,
  output logic [WC_W-1:0]   wc_count
);

  if (DEPTH % 4 != 0 || DEPTH < 4) begin : g_bad_depth
    $error("DEPTH must be a positive multiple of 4");
  end

  logic accept, full, ovr_evt, ovr_q, ovr_d;

  assign accept = in_valid && !rx_halt;

  rxwm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (accept),
    .wr_data     (in_data),
    .ovwr_mode   (cfg_ovwr),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .fill        (fill),
    .full        (full),
    .overrun_evt (ovr_evt)
  );

  rxwm_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill     (fill),
    .req_sel  (cfg_req_sel),
    .urg_en   (cfg_urg_en),
    .urg_lvl  (cfg_urg_lvl),
    .reg_wm   (cfg_reg_wm),
    .rx_req   (rx_req),
    .urg_flag (urg_flag)
  );

  rxwm_wordcnt #(.WC_W(WC_W)) u_wc (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (cfg_master),
    .wc_en     (wc_en),
    .load      (wc_load),
    .load_val  (wc_val),
    .word_in   (in_valid),
    .fifo_full (full),
    .halt      (rx_halt),
    .count     (wc_count)
  );

  // Sticky overrun: a new event beats a simultaneous clear
  always_comb ovr_d = ovr_evt || (ovr_q && !ovr_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign ovr_flag = ovr_q;

endmodule

// File: rtl/rx_wm_fifo_chk.sv
module rx_wm_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int WC_W   = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  fill,
  input logic [2:0]        cfg_req_sel,
  input logic              cfg_ovwr,
  input logic              cfg_urg_en,
  input logic [1:0]        cfg_reg_wm,
  input logic              cfg_master,
  input logic              wc_en,
  input logic              wc_load,
  input logic              ovr_clr,
  input logic              rx_req,
  input logic              urg_flag,
  input logic              ovr_flag,
  input logic              rx_halt,
  input logic [WC_W-1:0]   wc_count
);

  localparam int QTR = DEPTH / 4;

  logic at_full, push_full, low_met;

  always_comb begin
    at_full   = (int'(fill) == DEPTH);
    push_full = in_valid && !rx_halt && at_full && !rd_en;
    low_met   = (cfg_reg_wm == 2'd0) ? (fill == '0)
                                     : (int'(fill) < int'(cfg_reg_wm) * QTR);
  end

  assert_reserved_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_sel >= 3'd6) |-> !rx_req);

  assert_discard_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_full && !cfg_ovwr) |=> (at_full && $stable(rd_data)));

  assert_overwrite_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_full && cfg_ovwr) |=> at_full);

  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_full |=> ovr_flag);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  assert_urg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (urg_flag && cfg_urg_en && !low_met) |=> urg_flag);

  assert_urg_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_urg_en |=> !urg_flag);

  assert_wc_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && wc_en && in_valid && !rx_halt && !wc_load)
      |=> (wc_count == $past(wc_count) - 1'b1));

  assert_halt_no_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt && !rd_en) |=> $stable(fill));

  assert_halt_no_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt && !ovr_flag) |=> !ovr_flag);

  assert_slave_no_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !rx_halt);

  assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

endmodule

bind rx_wm_fifo rx_wm_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .WC_W(WC_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .fill        (fill),
  .cfg_req_sel (cfg_req_sel),
  .cfg_ovwr    (cfg_ovwr),
  .cfg_urg_en  (cfg_urg_en),
  .cfg_reg_wm  (cfg_reg_wm),
  .cfg_master  (cfg_master),
  .wc_en       (wc_en),
  .wc_load     (wc_load),
  .ovr_clr     (ovr_clr),
  .rx_req      (rx_req),
  .urg_flag    (urg_flag),
  .ovr_flag    (ovr_flag),
  .rx_halt     (rx_halt),
  .wc_count    (wc_count)
);

// File: tb/sim_rx_wm_fifo.sv
module sim_rx_wm_fifo;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int WC_W   = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int QTR    = DEPTH / 4;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              rd_en;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  fill;
  logic [2:0]        cfg_req_sel;
  logic              cfg_ovwr, cfg_urg_en, cfg_master, wc_en, wc_load, ovr_clr;
  logic [1:0]        cfg_urg_lvl, cfg_reg_wm;
  logic [WC_W-1:0]   wc_val;
  logic              rx_req, urg_flag, ovr_flag, rx_halt;
  logic [WC_W-1:0]   wc_count;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int m_q[$];
  bit m_ovr, m_urg;
  int m_wc;

  rx_wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WC_W(WC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .fill(fill), .cfg_req_sel(cfg_req_sel),
    .cfg_ovwr(cfg_ovwr), .cfg_urg_en(cfg_urg_en), .cfg_urg_lvl(cfg_urg_lvl),
    .cfg_reg_wm(cfg_reg_wm), .cfg_master(cfg_master), .wc_en(wc_en),
    .wc_load(wc_load), .wc_val(wc_val), .ovr_clr(ovr_clr), .rx_req(rx_req),
    .urg_flag(urg_flag), .ovr_flag(ovr_flag), .rx_halt(rx_halt),
    .wc_count(wc_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit exp_req(int n, int sel);
    case (sel)
      1: return n != 0;
      2: return n >= QTR;
      3: return n >= 2 * QTR;
      4: return n >= 3 * QTR;
      5: return n == DEPTH;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_halt(int n, int wc, bit mst, bit en);
    return mst && en && (wc == 0 || n == DEPTH);
  endfunction

  function automatic bit low_level(int n, int code);
    return (code == 0) ? (n == 0) : (n < code * QTR);
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int n = m_q.size();
    cmp("R11", "fill", int'(fill), n);
    if (n != 0) cmp("R11", "rd_data", int'(rd_data), m_q[0]);
    cmp((cfg_req_sel >= 3'd6) ? "R2" : "R1", "rx_req", int'(rx_req),
        int'(exp_req(n, int'(cfg_req_sel))));
    cmp("R7", "urg_flag", int'(urg_flag), int'(m_urg));
    cmp("R5", "ovr_flag", int'(ovr_flag), int'(m_ovr));
    cmp(cfg_master ? "R9" : "R10", "rx_halt", int'(rx_halt),
        int'(exp_halt(n, m_wc, cfg_master, wc_en)));
    cmp("R8", "wc_count", int'(wc_count), m_wc);
  endtask

  // Advance one clock: model next state from pre-edge state and inputs
  task automatic step();
    int  n      = m_q.size();
    bit  full   = (n == DEPTH);
    bit  active = cfg_master && wc_en;
    bit  halt   = exp_halt(n, m_wc, cfg_master, wc_en);
    bit  pop    = rd_en && n != 0;
    bit  acc    = in_valid && !halt;
    bit  wr     = acc && (!full || pop || cfg_ovwr);
    bit  ovr_ev = acc && full && !pop;
    bit  set_u  = n >= (int'(cfg_urg_lvl) + 1) * QTR;
    bit  clr_u  = low_level(n, int'(cfg_reg_wm));
    bit  n_urg  = cfg_urg_en && (set_u || (m_urg && !clr_u));
    bit  n_ovr  = ovr_ev || (m_ovr && !ovr_clr);
    int  n_wc   = m_wc;
    if (wc_load) n_wc = int'(wc_val);
    else if (active && acc) n_wc = m_wc - 1;
    @(posedge clk);
    #1;
    if (pop) void'(m_q.pop_front());
    if (wr) begin
      if (full && !pop) void'(m_q.pop_front());
      m_q.push_back(int'(in_data));
    end
    m_urg = n_urg;
    m_ovr = n_ovr;
    m_wc  = n_wc;
    check_all();
  endtask

  task automatic idle_inputs();
    in_valid = 0; rd_en = 0; wc_load = 0; ovr_clr = 0; in_data = '0; wc_val = '0;
  endtask

  task automatic push(int v);
    in_valid = 1; in_data = DATA_W'(v); step(); in_valid = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle_inputs();
    cfg_req_sel = 3'd0; cfg_ovwr = 0; cfg_urg_en = 0; cfg_urg_lvl = 2'd0;
    cfg_reg_wm = 2'd0; cfg_master = 0; wc_en = 0;
    m_ovr = 0; m_urg = 0; m_wc = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check_all();
    rst_n = 1;
    step();

    // R12: request follows the first push by one edge
    cfg_req_sel = 3'd1;
    #1;
    cmp("R12", "rx_req before push", int'(rx_req), 0);
    push(16'hA5A5);
    cmp("R12", "rx_req after push", int'(rx_req), 1);

    // R3: fill to full in drop mode, then one extra word
    for (int i = 1; i < DEPTH; i++) push(16'h1000 + i);
    cfg_req_sel = 3'd5;
    #1;
    cmp("R1", "full request", int'(rx_req), 1);
    push(16'hDEAD);
    cmp("R3", "fill kept", int'(fill), DEPTH);
    cmp("R3", "head kept", int'(rd_data), 16'hA5A5);
    cmp("R5", "overrun set", int'(ovr_flag), 1);

    // R5: clear, then R4 overwrite
    ovr_clr = 1; step(); ovr_clr = 0;
    cmp("R5", "overrun cleared", int'(ovr_flag), 0);
    cfg_ovwr = 1;
    push(16'hBEEF);
    cmp("R4", "fill full", int'(fill), DEPTH);
    cmp("R4", "oldest dropped", int'(rd_data), 16'h1001);

    // R6: urgent set at full level with lower release at empty
    cfg_urg_en = 1; cfg_urg_lvl = 2'd3; cfg_reg_wm = 2'd0;
    step();
    cmp("R6", "urgent set", int'(urg_flag), 1);
    rd_en = 1;
    for (int i = 0; i < DEPTH; i++) step();
    rd_en = 0;
    step();
    cmp("R7", "urgent released", int'(urg_flag), 0);

    // R10: slave ignores counter enable
    cfg_master = 0; wc_en = 1;
    push(16'h0055);
    cmp("R10", "slave no halt", int'(rx_halt), 0);
    cmp("R10", "slave count idle", int'(wc_count), 0);

    // R9: master with zero count halts and drops words
    cfg_master = 1;
    #1;
    cmp("R9", "halt at zero", int'(rx_halt), 1);
    push(16'h0066);
    cmp("R9", "no push while halted", int'(fill), 1);
    wc_load = 1; wc_val = 16'd2; step(); wc_load = 0;
    push(16'h0077);
    push(16'h0088);
    cmp("R8", "counted down", int'(wc_count), 0);
    cmp("R9", "two accepted", int'(fill), 3);

    // Random phases
    for (int ph = 0; ph < 16; ph++) begin
      int rd_pct = 20 + int'($urandom % 60);
      int wr_pct = 30 + int'($urandom % 60);
      cfg_req_sel = 3'($urandom % 8);
      cfg_ovwr    = 1'($urandom % 2);
      cfg_urg_en  = ($urandom % 4) != 0;
      cfg_urg_lvl = 2'($urandom % 4);
      cfg_reg_wm  = 2'($urandom % 4);
      cfg_master  = 1'($urandom % 2);
      wc_en       = 1'($urandom % 2);
      for (int c = 0; c < 300; c++) begin
        in_valid = int'($urandom % 100) < wr_pct;
        in_data  = DATA_W'($urandom);
        rd_en    = int'($urandom % 100) < rd_pct;
        ovr_clr  = ($urandom % 20) == 0;
        wc_load  = ($urandom % 40) == 0;
        wc_val   = WC_W'($urandom % 24);
        step();
      end
      idle_inputs();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule